// File: doc/BRIEF.md
# Bit-Stuffing HDLC Frame Transmitter

This block serialises bit-oriented frames onto a single data line. A frame opens with the value held in a flag register and continues with one address byte from an address register. The data bytes follow, taken through a valid/ready byte port. After them comes a 16-bit frame check sequence, and a second copy of the flag closes the frame. All fields are sent least significant bit first, one bit per cycle in which the transmit clock enable is high.

A transparency stage sits between the field shifter and the line. It counts consecutive ones in the address, data and check fields and inserts a zero after every fifth. The count carries across byte and field boundaries, so a zero can be inserted between the last check bit and the closing flag. The stage is bypassed while a flag is sent. The check sequence is computed over the address and data bits before stuffing and is itself stuffed. A single-byte holding buffer decouples the byte source from the bit rate. If no byte is held when the shifter needs one, the shifter waits. Between frames the line idles high.

Top module: `hdlc_tx`

## Requirements
- R1: After reset, txd_o is 1 and tx_ready_o is 1. The flag register holds 0x7E and the address register holds 0xFF.
- R2: While no frame is in progress, every emitted bit is 1.
- R3: A frame begins with the 8 flag register bits, LSB first.
- R4: The address register byte is the first field after the opening flag, LSB first.
- R5: Data bytes are sent in handshake order, LSB first, and a byte is accepted on a clock edge with tx_valid_i and tx_ready_o both high. After an accepted byte, tx_ready_o is 0 on the next cycle. The byte accepted with tx_last_i high is the last data byte of the frame. A frame starts once a byte is held.
- R6: The check sequence is the complement of a CRC with reflected polynomial 0x8408 (x^16+x^12+x^5+1), preset to 0xFFFF and run over the address and data bits. It is sent LSB first. Over the destuffed address, data and check bits, a receiver CRC with the same algorithm ends at 0xF0B8.
- R7: In the address, data and check fields, a 0 is inserted after every five consecutive 1s. The run count spans byte and field boundaries, including the boundary into the closing flag, and any emitted 0 resets it.
- R8: No zero is inserted inside a flag, so a flag with six consecutive 1s is sent unchanged.
- R9: After the check sequence, the flag register value is sent once more and the line then returns to idle 1s.
- R10: tx_ready_o is 0 while txd_o carries an inserted zero.
- R11: txd_o changes only on a clock edge where bit_en_i is high, and each such edge emits exactly one bit.
- R12: A clock edge with flag_we_i high loads cfg_data_i into the flag register. A clock edge with addr_we_i high loads cfg_data_i into the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Transmit bit-rate enable, one bit per high cycle |
| cfg_data_i | input | 8 | Write data for the flag and address registers |
| flag_we_i | input | 1 | Load the flag register |
| addr_we_i | input | 1 | Load the address register |
| tx_data_i | input | 8 | Data byte |
| tx_valid_i | input | 1 | Data byte valid |
| tx_last_i | input | 1 | Byte is the last of the frame |
| tx_ready_o | output | 1 | Holding buffer can accept a byte |
| txd_o | output | 1 | Serial data out |

## Verification
A bit is registered into txd_o on the clock edge where bit_en_i is high. The bench records it at the falling edge that follows, together with tx_ready_o, because that flag is updated on the same edge. A byte counts as accepted on the first rising edge at which tx_ready_o was high at the preceding falling edge. The bench raises tx_valid_i two time units after a rising edge and drops it two units after the edge that accepts the byte. Each frame is then compared in bit-index order against a stream built by the bench: the flag, the stuffed address, data and check fields, and the closing flag. The comparison starts at the first 0 bit, and the recorded stream is also destuffed to recover the bytes and the CRC residue.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FLAG_OPEN,
    S_ADDR,
    S_DATA,
    S_WAIT,
    S_FCS,
    S_FLAG_CLOSE
  } tx_state_e;

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned FCS_W      = 16;
  localparam int unsigned ONES_RUN   = 5;
  localparam logic [FCS_W-1:0] FCS_POLY   = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;
endpackage

// File: rtl/hdlc_tx_cfg.sv
module hdlc_tx_cfg #(
  parameter int unsigned      W          = 8,
  parameter logic [W-1:0]     FLAG_RESET = 8'h7E,
  parameter logic [W-1:0]     ADDR_RESET = 8'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] wdata_i,
  input  logic         flag_we_i,
  input  logic         addr_we_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] flag_q, addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= FLAG_RESET;
      addr_q <= ADDR_RESET;
    end else begin
      if (flag_we_i) flag_q <= wdata_i;
      if (addr_we_i) addr_q <= wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/hdlc_tx_hold.sv
module hdlc_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         last_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic         block_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] data_o,
  output logic         last_o
);
  logic         full_q, last_q;
  logic [W-1:0] data_q;
  logic         accept;

  assign ready_o = !full_q && !block_i;
  assign accept  = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      last_q <= last_i;
      data_q <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign last_o = last_q;
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int unsigned      W      = 16,
  parameter logic [W-1:0]     POLY   = 16'h8408,
  parameter logic [W-1:0]     PRESET = 16'hFFFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_nxt_o
);
  logic [W-1:0] crc_q, stepped;

  // reflected form: LSB-first bit order
  always_comb begin
    stepped = crc_q >> 1;
    if (crc_q[0] ^ bit_i) stepped = stepped ^ POLY;
  end

  assign crc_nxt_o = en_i ? stepped : crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= PRESET;
    else if (init_i) crc_q <= PRESET;
    else             crc_q <= crc_nxt_o;
  end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8,
  parameter int unsigned CHK_BITS  = 16,
  parameter int unsigned RUN_LEN   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_en_i,
  input  logic [BYTE_BITS-1:0] flag_i,
  input  logic [BYTE_BITS-1:0] addr_i,
  input  logic                 hold_full_i,
  input  logic [BYTE_BITS-1:0] hold_data_i,
  input  logic                 hold_last_i,
  input  logic [CHK_BITS-1:0]  crc_nxt_i,
  output logic                 take_o,
  output logic                 crc_init_o,
  output logic                 crc_en_o,
  output logic                 crc_bit_o,
  output logic                 stuff_o,
  output logic                 txd_o
);
  localparam int unsigned SH_W   = CHK_BITS;
  localparam int unsigned CNT_W  = $clog2(SH_W);
  localparam int unsigned ONES_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(BYTE_BITS - 1);
  localparam logic [CNT_W-1:0]  CHK_END  = CNT_W'(CHK_BITS - 1);
  localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(RUN_LEN);

  tx_state_e         state_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ONES_W-1:0] ones_q;
  logic              last_q, txd_q, stuff_q;

  logic busy, stuffed_fld, stuff_now, shift_now, field_last, need_byte;

  always_comb begin
    busy        = (state_q != S_IDLE) && (state_q != S_WAIT);
    stuffed_fld = (state_q == S_ADDR) || (state_q == S_DATA) || (state_q == S_FCS);
    // run count is zero inside flags, so only a pending run from the FCS can stuff there
    stuff_now   = bit_en_i && busy && (ones_q == RUN_MAX);
    shift_now   = bit_en_i && busy && !stuff_now;
    field_last  = (cnt_q == ((state_q == S_FCS) ? CHK_END : BYTE_END));
    need_byte   = (shift_now && field_last &&
                   ((state_q == S_ADDR) || ((state_q == S_DATA) && !last_q))) ||
                  (state_q == S_WAIT);
  end

  assign take_o     = need_byte && hold_full_i;
  assign crc_init_o = bit_en_i && (state_q == S_IDLE) && hold_full_i;
  assign crc_en_o   = shift_now && ((state_q == S_ADDR) || (state_q == S_DATA));
  assign crc_bit_o  = sh_q[0];
  assign stuff_o    = stuff_q;
  assign txd_o      = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      ones_q  <= '0;
      last_q  <= 1'b0;
      txd_q   <= 1'b1;
      stuff_q <= 1'b0;
    end else if (state_q == S_WAIT) begin
      if (hold_full_i) begin
        state_q <= S_DATA;
        sh_q    <= SH_W'(hold_data_i);
        last_q  <= hold_last_i;
      end
    end else if (state_q == S_IDLE) begin
      if (bit_en_i) begin
        txd_q   <= 1'b1;
        stuff_q <= 1'b0;
        if (hold_full_i) begin
          state_q <= S_FLAG_OPEN;
          sh_q    <= SH_W'(flag_i);
          cnt_q   <= '0;
          ones_q  <= '0;
        end
      end
    end else if (stuff_now) begin
      txd_q   <= 1'b0;
      stuff_q <= 1'b1;
      ones_q  <= '0;
    end else if (shift_now) begin
      txd_q   <= sh_q[0];
      stuff_q <= 1'b0;
      sh_q    <= sh_q >> 1;
      cnt_q   <= cnt_q + CNT_W'(1);
      if (stuffed_fld && sh_q[0]) ones_q <= ones_q + ONES_W'(1);
      else                        ones_q <= '0;
      if (field_last) begin
        cnt_q <= '0;
        unique case (state_q)
          S_FLAG_OPEN: begin
            state_q <= S_ADDR;
            sh_q    <= SH_W'(addr_i);
          end
          S_ADDR, S_DATA: begin
            if ((state_q == S_DATA) && last_q) begin
              state_q <= S_FCS;
              sh_q    <= ~crc_nxt_i;
            end else if (hold_full_i) begin
              state_q <= S_DATA;
              sh_q    <= SH_W'(hold_data_i);
              last_q  <= hold_last_i;
            end else begin
              state_q <= S_WAIT;
            end
          end
          S_FCS: begin
            state_q <= S_FLAG_CLOSE;
            sh_q    <= SH_W'(flag_i);
          end
          S_FLAG_CLOSE: state_q <= S_IDLE;
          default:      state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
  import hdlc_tx_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_RESET = 8'h7E,
  parameter logic [BYTE_W-1:0] ADDR_RESET = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [BYTE_W-1:0] cfg_data_i,
  input  logic              flag_we_i,
  input  logic              addr_we_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              txd_o
);
  logic [BYTE_W-1:0] flag_reg, addr_reg, hold_data;
  logic              hold_full, hold_last, take, stuffing;
  logic              crc_init, crc_en, crc_bit;
  logic [FCS_W-1:0]  crc_nxt;

  hdlc_tx_cfg #(.W(BYTE_W), .FLAG_RESET(FLAG_RESET), .ADDR_RESET(ADDR_RESET)) u_cfg (
    .clk_i, .rst_ni,
    .wdata_i(cfg_data_i), .flag_we_i, .addr_we_i,
    .flag_o(flag_reg), .addr_o(addr_reg)
  );

  hdlc_tx_hold #(.W(BYTE_W)) u_hold (
    .clk_i, .rst_ni,
    .data_i(tx_data_i), .last_i(tx_last_i), .valid_i(tx_valid_i), .ready_o(tx_ready_o),
    .block_i(stuffing), .take_i(take),
    .full_o(hold_full), .data_o(hold_data), .last_o(hold_last)
  );

  hdlc_tx_crc #(.W(FCS_W), .POLY(FCS_POLY), .PRESET(FCS_PRESET)) u_crc (
    .clk_i, .rst_ni,
    .init_i(crc_init), .en_i(crc_en), .bit_i(crc_bit), .crc_nxt_o(crc_nxt)
  );

  hdlc_tx_ctrl #(.BYTE_BITS(BYTE_W), .CHK_BITS(FCS_W), .RUN_LEN(ONES_RUN)) u_ctrl (
    .clk_i, .rst_ni, .bit_en_i,
    .flag_i(flag_reg), .addr_i(addr_reg),
    .hold_full_i(hold_full), .hold_data_i(hold_data), .hold_last_i(hold_last),
    .crc_nxt_i(crc_nxt),
    .take_o(take), .crc_init_o(crc_init), .crc_en_o(crc_en), .crc_bit_o(crc_bit),
    .stuff_o(stuffing), .txd_o
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
  import hdlc_tx_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      bit_en_i,
  input logic      tx_valid_i,
  input logic      tx_ready_o,
  input logic      txd_o,
  input tx_state_e state_i,
  input logic [2:0] ones_i
);
  assert_line_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> $stable(txd_o));

  assert_idle_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_IDLE && $past(state_i == S_IDLE) && $past(bit_en_i)) |-> txd_o);

  assert_accept_fills_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o);

  assert_run_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_i <= 3'(ONES_RUN));

  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_FLAG_OPEN) |-> (ones_i == 3'd0));
endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
  .clk_i, .rst_ni, .bit_en_i, .tx_valid_i, .tx_ready_o, .txd_o,
  .state_i(u_ctrl.state_q), .ones_i(u_ctrl.ones_q)
);

// File: tb/hdlc_tx_tb.sv
module hdlc_tx_tb;
  logic       clk = 1'b0, rst_n = 1'b1;
  logic       bit_en = 1'b0, flag_we = 1'b0, addr_we = 1'b0;
  logic [7:0] cfg_data = '0, tx_data = '0;
  logic       tx_valid = 1'b0, tx_last = 1'b0;
  logic       tx_ready, txd;

  always #4 clk = ~clk;

  hdlc_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .cfg_data_i(cfg_data),
    .flag_we_i(flag_we), .addr_we_i(addr_we), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_last_i(tx_last), .tx_ready_o(tx_ready), .txd_o(txd)
  );

  int n_chk = 0, n_bad = 0;
  bit en_on = 1'b0, done = 1'b0;
  bit en_s = 1'b0, last_txd = 1'b1;
  int stable_bad = 0;
  bit cap[$];
  bit rdy[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    bit_en = en_on && ($urandom_range(0, 1) == 1);
  end

  always @(negedge clk) begin
    if (en_s) begin
      cap.push_back(txd);
      rdy.push_back(tx_ready);
    end else if (rst_n && txd != last_txd) begin
      stable_bad++;
    end
    last_txd = txd;
    en_s = bit_en;
  end

  function automatic logic [15:0] crc_bits(input bit b[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[i]) begin
      bit fb = c[0] ^ b[i];
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic cfg_write(input bit is_flag, input logic [7:0] v);
    @(posedge clk); #2;
    cfg_data = v;
    if (is_flag) flag_we = 1'b1; else addr_we = 1'b1;
    @(posedge clk); #2;
    flag_we = 1'b0;
    addr_we = 1'b0;
  endtask

  task automatic run_frame(input logic [7:0] addr, input logic [7:0] flag,
                           input logic [7:0] dat[$], input string tag);
    bit pay[$];
    bit exp[$];
    bit body[$];
    int spos[$];
    logic [15:0] fcs;
    int ones, start, len, bad, idx;
    for (int k = 0; k < 8; k++) pay.push_back(addr[k]);
    foreach (dat[i]) for (int k = 0; k < 8; k++) pay.push_back(dat[i][k]);
    fcs = ~crc_bits(pay);
    for (int k = 0; k < 16; k++) pay.push_back(fcs[k]);
    for (int k = 0; k < 8; k++) exp.push_back(flag[k]);
    ones = 0;
    foreach (pay[i]) begin
      exp.push_back(pay[i]);
      ones = pay[i] ? ones + 1 : 0;
      if (ones == 5) begin
        exp.push_back(1'b0);
        spos.push_back(exp.size() - 1);
        ones = 0;
      end
    end
    for (int k = 0; k < 8; k++) exp.push_back(flag[k]);
    len = exp.size();

    cap.delete();
    rdy.delete();
    stable_bad = 0;

    foreach (dat[i]) begin
      @(posedge clk); #2;
      tx_valid = 1'b1;
      tx_data  = dat[i];
      tx_last  = (i == dat.size() - 1);
      do @(negedge clk); while (!tx_ready);
      @(posedge clk); #2;
      tx_valid = 1'b0;
      tx_last  = 1'b0;
    end

    start = -1;
    forever begin
      @(negedge clk);
      start = -1;
      foreach (cap[i]) if (start < 0 && cap[i] == 1'b0) start = i;
      if (start >= 0 && cap.size() >= start + len + 6) break;
    end

    bad = 0;
    for (int i = 0; i < start; i++) if (!cap[i]) bad++;
    for (int i = start + len; i < cap.size(); i++) if (!cap[i]) bad++;
    chk(bad == 0, "R2", {tag, " idle bits low"}, bad, 0);

    bad = 0;
    for (int i = 0; i < 8; i++) if (cap[start + i] != exp[i]) bad++;
    chk(bad == 0, "R3 R8", {tag, " opening flag bits"}, bad, 0);

    idx = -1;
    for (int i = 8; i < len - 8; i++) if (idx < 0 && cap[start + i] != exp[i]) idx = i;
    chk(idx < 0, "R7", {tag, " stuffed body first bad bit"}, idx, 32'hFFFFFFFF);

    bad = 0;
    for (int i = len - 8; i < len; i++) if (cap[start + i] != exp[i]) bad++;
    chk(bad == 0, "R9", {tag, " closing flag bits"}, bad, 0);

    bad = 0;
    foreach (spos[i]) if (rdy[start + spos[i]]) bad++;
    chk(bad == 0, "R10", {tag, " ready high on inserted zero"}, bad, 0);

    chk(stable_bad == 0, "R11", {tag, " txd moved without enable"}, stable_bad, 0);

    // destuff the recorded body independently of the expected stream
    ones = 0;
    for (int i = start + 8; i < start + len - 8; i++) begin
      if (ones == 5) begin
        ones = 0;
        continue;
      end
      body.push_back(cap[i]);
      ones = cap[i] ? ones + 1 : 0;
    end
    chk(body.size() == (dat.size() + 3) * 8, "R5", {tag, " destuffed bit count"},
        body.size(), (dat.size() + 3) * 8);
    if (body.size() == (dat.size() + 3) * 8) begin
      logic [7:0] b;
      for (int k = 0; k < 8; k++) b[k] = body[k];
      chk(b == addr, "R4 R12", {tag, " address byte"}, b, addr);
      bad = 0;
      foreach (dat[i]) begin
        for (int k = 0; k < 8; k++) b[k] = body[8 + i * 8 + k];
        if (b != dat[i]) bad++;
      end
      chk(bad == 0, "R5", {tag, " data bytes wrong"}, bad, 0);
      chk(crc_bits(body) == 16'hF0B8, "R6", {tag, " receiver residue"},
          crc_bits(body), 16'hF0B8);
    end
  endtask

  initial begin
    #(8 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d[$];
    logic [7:0] a;
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
    en_on = 1'b1;

    // R1: reset flag 0x7E and address 0xFF, long ones runs across bytes
    d = '{8'hFF, 8'hFF, 8'hFF};
    run_frame(8'hFF, 8'h7E, d, "R1 reset regs, all ones");

    cfg_write(1'b0, 8'h01);
    d = '{8'h1F, 8'hF8, 8'h3E};
    run_frame(8'h01, 8'h7E, d, "byte boundary runs");

    cfg_write(1'b0, 8'hAA);
    d = '{8'h00};
    run_frame(8'hAA, 8'h7E, d, "single byte");

    // R12: flag register write
    cfg_write(1'b1, 8'h3C);
    cfg_write(1'b0, 8'h7C);
    d = '{8'hF0, 8'h0F};
    run_frame(8'h7C, 8'h3C, d, "R12 new flag");
    cfg_write(1'b1, 8'h7E);

    for (int f = 0; f < 8; f++) begin
      a = 8'($urandom);
      cfg_write(1'b0, a);
      d.delete();
      for (int i = 0; i < $urandom_range(1, 10); i++)
        d.push_back(($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom));
      run_frame(a, 8'h7E, d, "random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule